// File: doc/BRIEF.md
# Multi-Rate Punctured Convolutional Encoder

This block turns a serial stream of data bits into a serial stream of channel bits, one channel bit per clock. Internally it is a rate-1/2 convolutional encoder: every data bit yields two parity symbols, one per generator polynomial. The constraint length can be chosen at run time from three values (3, 4 and 7). A puncturing stage drops selected symbols according to a fixed pattern per rate, so the same encoder also delivers rates 2/3 and 3/4.

Data bits enter through a valid/ready handshake. The output has no back-pressure. Each channel bit is tagged with the generator that produced it and with its puncture column. Configuration is taken only while the block is idle. The block is idle after reset and after a flush has completed. A flush request terminates the trellis by encoding zero bits until the encoder state is all zeros. The block then returns to idle and restarts its puncture pattern at the first column.

Top module: `conv_punct_enc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `cfg_k`=2 (constraint length 7), the two symbols of each data bit are the modulo-2 sums of the current bit and the last six bits, tapped by the octal generators 133 (first symbol, `out_gen`=0) and 171 (second symbol, `out_gen`=1). The most significant generator bit taps the current input bit.
- R3: With `cfg_k`=0 (constraint length 3) the generators are octal 7 and 5. With `cfg_k`=1 (constraint length 4) they are octal 15 and 17. The first-listed generator is `out_gen`=0 in both cases.
- R4: With `cfg_rate`=0 (rate 1/2) both symbols of every data bit are sent. The `out_gen`=0 symbol comes first and `out_col` is always 0.
- R5: With `cfg_rate`=1 (rate 2/3) the pattern has two columns. Column 0 sends both symbols. Column 1 sends only the `out_gen`=0 symbol.
- R6: With `cfg_rate`=2 or 3 (rate 3/4) the pattern has three columns. Column 0 sends both symbols, column 1 sends only the `out_gen`=1 symbol, and column 2 sends only the `out_gen`=0 symbol. The column index returns to 0 after the last column.
- R7: `in_ready` is 0 during any cycle in which the current column still has two symbols left to send. The output carries at most one channel bit per cycle, with no gaps inside a column.
- R8: `cfg_k` and `cfg_rate` are taken only while idle, at the cycle of the first accepted bit. Changes made while encoding have no effect until a flush completes.
- R9: A one-cycle `flush` pulse while encoding appends K-1 zero bits, which are punctured as usual with the column sequence continuing. Afterwards the block is idle with a zero state, and its next bit uses column 0.
- R10: A `flush` pulse while idle produces no output and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_k | input | 2 | Constraint length select: 0→3, 1→4, 2 or 3→7 |
| cfg_rate | input | 2 | Rate select: 0→1/2, 1→2/3, 2 or 3→3/4 |
| flush | input | 1 | Request to terminate the trellis with zero bits |
| in_valid | input | 1 | Data bit offered |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Block accepts a data bit this cycle |
| out_valid | output | 1 | Channel bit present |
| out_bit | output | 1 | Channel bit |
| out_gen | output | 1 | Generator that produced the channel bit |
| out_col | output | 2 | Puncture column of the channel bit |

## Verification
The assertions assume that `flush` is only pulsed and is not held through a whole termination. They also assume that configuration inputs carry their intended value on the cycle the first bit is accepted. The bench sets the configuration before offering data and drives every input just after a falling edge. It raises `flush` for a single cycle only after the last data bit has been taken. It then waits long enough for the tail and the drain to finish before the next scenario starts.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
    localparam int MEM_MAX = 6;
    localparam int TAPS    = MEM_MAX + 1;
    localparam int COLW    = 2;
    localparam int TCW     = $clog2(MEM_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [1:0]        kc;
        logic [1:0]        rc;
        logic [MEM_MAX-1:0] sr;
        logic [1:0]        sym;
        logic [1:0]        rem;
        logic [COLW-1:0]   col;
        logic [COLW-1:0]   ccol;
        logic [TCW-1:0]    tcnt;
        logic              pend;
    } regs_t;

    // Tap vector indexed by delay: bit j weights the bit seen j steps ago.
    function automatic logic [TAPS-1:0] taps(input logic [1:0] kc, input logic which);
        logic [TAPS-1:0] g;
        logic [TAPS-1:0] t;
        int k;
        case (kc)
            2'd0:    begin k = 3; g = which ? 7'o5   : 7'o7;   end
            2'd1:    begin k = 4; g = which ? 7'o17  : 7'o15;  end
            default: begin k = 7; g = which ? 7'o171 : 7'o133; end
        endcase
        t = '0;
        for (int j = 0; j < TAPS; j++) begin
            if (j < k) t[j] = g[k-1-j];
        end
        return t;
    endfunction

    function automatic logic [TCW-1:0] mem_len(input logic [1:0] kc);
        case (kc)
            2'd0:    return TCW'(2);
            2'd1:    return TCW'(3);
            default: return TCW'(MEM_MAX);
        endcase
    endfunction
endpackage

// File: rtl/cpe_encoder.sv
module cpe_encoder
    import cpe_pkg::*;
#(
    parameter int MEM = MEM_MAX
) (
    input  logic           u,
    input  logic [MEM-1:0] hist,
    input  logic [1:0]     kc,
    output logic [1:0]     sym
);
    logic [MEM:0] window;
    assign window = {hist, u};

    for (genvar gi = 0; gi < 2; gi++) begin : g_gen
        logic [TAPS-1:0] tv;
        assign tv      = taps(kc, 1'(gi));
        assign sym[gi] = ^(window & tv[MEM:0]);
    end
endmodule

// File: rtl/cpe_punct.sv
module cpe_punct
    import cpe_pkg::*;
(
    input  logic [1:0]      rc,
    input  logic [COLW-1:0] col,
    output logic [1:0]      keep,
    output logic            last
);
    // keep[0]: first-generator symbol, keep[1]: second-generator symbol
    always_comb begin
        case (rc)
            2'd0: begin
                keep = 2'b11;
                last = 1'b1;
            end
            2'd1: begin
                keep = (col == '0) ? 2'b11 : 2'b01;
                last = (col == COLW'(1));
            end
            default: begin
                case (col)
                    COLW'(0): keep = 2'b11;
                    COLW'(1): keep = 2'b10;
                    default:  keep = 2'b01;
                endcase
                last = (col == COLW'(2));
            end
        endcase
    end
endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
    import cpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_k,
    input  logic [1:0] cfg_rate,
    input  logic       flush,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       in_ready,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_gen,
    output logic [1:0] out_col
);
    regs_t q, d;

    logic [1:0]      eff_k, eff_rate;
    logic            slot_free, want_flush, accept, tail_step, produce, u;
    logic [1:0]      enc_sym, keep;
    logic            col_last;
    logic [TCW-1:0]  mlen;

    assign eff_k      = (q.st == ST_IDLE) ? cfg_k    : q.kc;
    assign eff_rate   = (q.st == ST_IDLE) ? cfg_rate : q.rc;
    assign mlen       = mem_len(eff_k);
    assign slot_free  = (q.rem != 2'b11);
    assign want_flush = flush | q.pend;
    assign in_ready   = (q.st != ST_TAIL) && !want_flush && slot_free;
    assign accept     = in_valid && in_ready;
    assign tail_step  = (q.st == ST_TAIL) && slot_free && (q.tcnt < mlen);
    assign produce    = accept || tail_step;
    assign u          = accept ? in_bit : 1'b0;

    cpe_encoder #(.MEM(MEM_MAX)) u_enc (
        .u    (u),
        .hist (q.sr),
        .kc   (eff_k),
        .sym  (enc_sym)
    );

    cpe_punct u_punct (
        .rc   (eff_rate),
        .col  (q.col),
        .keep (keep),
        .last (col_last)
    );

    always_comb begin
        d = q;
        // serializer: first-generator symbol leaves before the second
        d.rem = (q.rem == 2'b11) ? 2'b10 : 2'b00;
        if (produce) begin
            d.sr   = {q.sr[MEM_MAX-2:0], u};
            d.sym  = enc_sym;
            d.rem  = keep;
            d.ccol = q.col;
            d.col  = col_last ? '0 : q.col + COLW'(1);
        end
        if (tail_step) d.tcnt = q.tcnt + TCW'(1);
        case (q.st)
            ST_IDLE: begin
                d.kc   = cfg_k;
                d.rc   = cfg_rate;
                d.pend = 1'b0;
                if (accept) d.st = ST_RUN;
            end
            ST_RUN: begin
                if (want_flush && slot_free) begin
                    d.st   = ST_TAIL;
                    d.tcnt = '0;
                    d.pend = 1'b0;
                end else if (flush) begin
                    d.pend = 1'b1;
                end
            end
            default: begin
                if ((q.tcnt == mlen) && (q.rem == 2'b00)) begin
                    d.st  = ST_IDLE;
                    d.sr  = '0;
                    d.col = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign out_valid = (q.rem != 2'b00);
    assign out_bit   = q.rem[0] ? q.sym[0] : q.sym[1];
    assign out_gen   = ~q.rem[0];
    assign out_col   = q.ccol;

    // R8: configuration frozen outside idle
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> ($stable(q.kc) && $stable(q.rc)));

    // R7: a full column is followed by its second symbol on the next cycle
    p_second_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_gen && q.rem[1]) |=> (out_valid && out_gen));

    // R9: idle always means a cleared trellis and nothing pending
    p_idle_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> ((q.sr == '0) && (q.col == '0) && !q.pend));

    // R9: no data accepted while the tail is running
    p_tail_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TAIL) |-> !in_ready);

    // R6: column index stays within the active pattern
    p_col_in_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |->
            ((q.rc == 2'd0) ? (q.col == '0) :
             (q.rc == 2'd1) ? (q.col <= COLW'(1)) : (q.col <= COLW'(2))));

    // R5: rate 2/3 column 1 carries only the first-generator symbol
    p_r23_col1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (q.rc == 2'd1) && (out_col == 2'd1)) |-> !out_gen);
endmodule

// File: tb/conv_punct_enc_tb.sv
module conv_punct_enc_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic [1:0] cfg_k = 0, cfg_rate = 0;
    logic flush = 0, in_valid = 0, in_bit = 0;
    logic in_ready, out_valid, out_bit, out_gen;
    logic [1:0] out_col;

    int n_chk = 0, n_bad = 0;
    logic [3:0] got[$];
    logic [3:0] exp_q[$];
    logic [5:0] m_hist;
    int m_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_punct_enc u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .cfg_rate(cfg_rate),
        .flush(flush), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
        .out_gen(out_gen), .out_col(out_col)
    );

    always @(negedge clk) if (rst_n && out_valid) got.push_back({out_col, out_gen, out_bit});

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // bench model: generators in octal, first listed is generator 0
    function automatic int gpoly(input int k, input int which);
        if (k == 3) return which ? 'o5 : 'o7;
        if (k == 4) return which ? 'o17 : 'o15;
        return which ? 'o171 : 'o133;
    endfunction

    task automatic model_bit(input int k, input int rate, input logic b);
        logic [1:0] s;
        logic [6:0] dl;
        logic [1:0] msk;
        int width;
        dl = {m_hist, b};
        for (int w = 0; w < 2; w++) begin
            int g;
            g = gpoly(k, w);
            s[w] = 0;
            for (int j = 0; j < k; j++) s[w] ^= (((g >> (k-1-j)) & 1) != 0) & dl[j];
        end
        width = (rate == 0) ? 1 : (rate == 1) ? 2 : 3;
        if (rate == 0) msk = 2'b11;
        else if (rate == 1) msk = (m_col == 0) ? 2'b11 : 2'b01;
        else msk = (m_col == 0) ? 2'b11 : (m_col == 1) ? 2'b10 : 2'b01;
        if (msk[0]) exp_q.push_back({2'(m_col), 1'b0, s[0]});
        if (msk[1]) exp_q.push_back({2'(m_col), 1'b1, s[1]});
        m_hist = {m_hist[4:0], b};
        m_col = (m_col + 1) % width;
    endtask

    task automatic model_flush(input int k, input int rate);
        for (int i = 0; i < k-1; i++) model_bit(k, rate, 1'b0);
        m_hist = 0;
        m_col = 0;
    endtask

    task automatic push(input logic b);
        in_valid = 1; in_bit = b;
        #1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic pulse_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
    endtask

    task automatic compare(input string req);
        check({req, " symbol count"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            check({req, " symbol {col,gen,bit}"}, int'(got[i]), int'(exp_q[i]));
        got.delete(); exp_q.delete();
    endtask

    task automatic run_stream(input string req, input int k, input int rate,
                              input logic [31:0] pat, input int n);
        cfg_k = (k == 3) ? 2'd0 : (k == 4) ? 2'd1 : 2'd2;
        cfg_rate = 2'(rate);
        for (int i = 0; i < n; i++) begin
            push(pat[i]);
            model_bit(k, rate, pat[i]);
        end
        pulse_flush();
        model_flush(k, rate);
        repeat (60) @(negedge clk);
        compare(req);
    endtask

    task automatic t_reset();
        check("R1 out_valid", out_valid, 0);
        check("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_k7_half();
        // R7: after accepting a bit at rate 1/2 the second symbol blocks input
        cfg_k = 2'd2; cfg_rate = 2'd0;
        push(1'b1); model_bit(7, 0, 1'b1);
        check("R7 in_ready low while pair pending", in_ready, 0);
        check("R7 first symbol valid", out_valid, 1);
        check("R4 first symbol generator 0", out_gen, 0);
        @(negedge clk);
        check("R7 second symbol back-to-back", {out_valid, out_gen}, 3);
        run_stream("R2 R4 K7 rate 1/2", 7, 0, 32'hB5C3_1E6D, 14);
    endtask

    task automatic t_cfg_hold();
        cfg_k = 2'd0; cfg_rate = 2'd0;
        push(1'b1); model_bit(3, 0, 1'b1);
        cfg_k = 2'd2; cfg_rate = 2'd2;   // must not take effect (R8)
        push(1'b1); model_bit(3, 0, 1'b1);
        push(1'b0); model_bit(3, 0, 1'b0);
        push(1'b1); model_bit(3, 0, 1'b1);
        pulse_flush(); model_flush(3, 0);
        repeat (60) @(negedge clk);
        compare("R8 config frozen during run");
        run_stream("R8 config taken after flush", 7, 2, 32'h0000_0F1D, 9);
    endtask

    task automatic t_idle_flush();
        got.delete();
        pulse_flush();
        repeat (20) @(negedge clk);
        check("R10 no output from idle flush", got.size(), 0);
        check("R10 still ready after idle flush", in_ready, 1);
    endtask

    initial begin
        m_hist = 0; m_col = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_k7_half();
        run_stream("R3 R5 R9 K3 rate 2/3", 3, 1, 32'h0000_2D97, 11);
        run_stream("R3 R6 R9 K4 rate 3/4", 4, 2, 32'h0000_6B3A, 10);
        run_stream("R2 R6 K7 rate 3/4 wrap", 7, 2, 32'h00C7_19E4, 20);
        run_stream("R3 R4 K4 rate 1/2", 4, 0, 32'h0000_00A7, 8);
        run_stream("R5 R9 K7 rate 2/3 odd length", 7, 1, 32'h0000_1F35, 13);
        t_cfg_hold();
        t_idle_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule